// File: doc/BRIEF.md
# Smart-Card Clock Divider with Glitch-Free Reload

This block derives the clock for a smart-card interface from a faster master clock. A 6-bit ratio field, written through a small register port, sets a first stage that counts the master clock and emits a single-cycle pulse every (ratio + 1) cycles. That pulse serves as the enable for a downstream elementary-time-unit divider. A toggle flop driven by the same pulse makes the card clock, which is a square wave with a period of 2 x (ratio + 1) master cycles.

Software may rewrite the ratio at any moment, including while the divider is running. The written value is held in a staging register. It moves into the running divisor only at the end of a count, so the card clock phase in progress always finishes at its old length and no shortened pulse can appear. A ratio of zero is treated the same as a ratio of one.

Top module: `sc_clkdiv`

## Requirements
- R1: While reset is held and right after its release, the readback is 0x0C, card_clk is low and etu_tick is low. The first card_clk low phase lasts 13 master cycles.
- R2: The readback returns the last written bits [5:0] in bits [5:0], and always returns 0 in bits [7:6]. Bits [7:6] of a write are discarded. A write is visible on the readback in the cycle after wr_en is sampled.
- R3: etu_tick is high for exactly one master cycle in every card_clk phase, and that cycle immediately precedes the card_clk transition. Two ticks are never back to back.
- R4: card_clk changes only on the clock edge that ends a tick cycle. Each high or low phase lasts E+1 master cycles, where E is the effective ratio that governs the phase.
- R5: A written ratio of 0 gives the same result as 1: phases of 2 master cycles and a card_clk period of 4 master cycles.
- R6: The ratio governing a phase is the staged value as it stood just before the card_clk transition that began the phase. A write made in the middle of a phase therefore never changes that phase's length.
- R7: A write sampled on the same edge that ends a tick does not affect the phase that edge begins. It first governs the phase after that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| wr_en | input | 1 | Write strobe for the ratio register |
| wr_data | input | 8 | Write data; bits [5:0] are the ratio |
| rd_data | output | 8 | Readback of the staged ratio, with bits [7:6] always zero |
| etu_tick | output | 1 | One-cycle pulse every (ratio+1) master cycles |
| card_clk | output | 1 | Card clock, toggled on each tick |

## Verification
The case that needs care is a register write landing on the same clock edge as a terminal count. On that edge the running divisor reloads from the staging register while the staging register itself takes the new value. The bench provokes this deliberately by waiting until it sees etu_tick high and driving the write in that same cycle. It then requires the next phase to keep the old length and the phase after it to take the new one. A phase monitor also judges every card_clk phase during hundreds of randomly timed writes. It predicts each phase length from the staged value held just before the transition that opened the phase.

// File: rtl/sc_clkdiv_pkg.sv
package sc_clkdiv_pkg;
  localparam int unsigned RATIO_W   = 6;
  localparam int unsigned PORT_W    = 8;
  localparam logic [RATIO_W-1:0] RATIO_RESET = 6'd12;
endpackage

// File: rtl/sc_ratio_reg.sv
module sc_ratio_reg
  import sc_clkdiv_pkg::*;
#(
  parameter int unsigned RW = RATIO_W,
  parameter int unsigned PW = PORT_W,
  parameter logic [RW-1:0] RST_VAL = RATIO_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  output logic [RW-1:0] staged,
  output logic [PW-1:0] rd_data
);
  localparam int unsigned PAD_W = PW - RW;

  logic [RW-1:0] staged_d;
  logic [RW-1:0] staged_q;

  always_comb begin
    staged_d = staged_q;
    if (wr_en) staged_d = wr_data[RW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) staged_q <= RST_VAL;
    else        staged_q <= staged_d;
  end

  assign staged  = staged_q;
  assign rd_data = {{PAD_W{1'b0}}, staged_q};
endmodule

// File: rtl/sc_ratio_counter.sv
module sc_ratio_counter
  import sc_clkdiv_pkg::*;
#(
  parameter int unsigned RW = RATIO_W,
  parameter logic [RW-1:0] RST_VAL = RATIO_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] staged,
  output logic          tick
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] run_q, run_d;
  logic [RW-1:0] limit;

  // a zero ratio counts like a ratio of one
  assign limit = (run_q == '0) ? {{(RW-1){1'b0}}, 1'b1} : run_q;
  assign tick  = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    run_d = run_q;
    if (tick) begin
      cnt_d = '0;
      run_d = staged;   // reload only at terminal count
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/sc_card_toggle.sv
module sc_card_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic card_clk
);
  logic ck_q, ck_d;

  always_comb begin
    ck_d = ck_q;
    if (tick) ck_d = ~ck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b0;
    else        ck_q <= ck_d;
  end

  assign card_clk = ck_q;
endmodule

// File: rtl/sc_clkdiv.sv
module sc_clkdiv
  import sc_clkdiv_pkg::*;
#(
  parameter int unsigned RW = RATIO_W,
  parameter int unsigned PW = PORT_W,
  parameter logic [RW-1:0] RST_VAL = RATIO_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] rd_data,
  output logic          etu_tick,
  output logic          card_clk
);
  logic [RW-1:0] staged;

  sc_ratio_reg #(.RW(RW), .PW(PW), .RST_VAL(RST_VAL)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .staged  (staged),
    .rd_data (rd_data)
  );

  sc_ratio_counter #(.RW(RW), .RST_VAL(RST_VAL)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .staged (staged),
    .tick   (etu_tick)
  );

  sc_card_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (etu_tick),
    .card_clk (card_clk)
  );
endmodule

// File: rtl/sc_clkdiv_checker.sv
module sc_clkdiv_checker #(
  parameter int unsigned RW = 6,
  parameter int unsigned PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [PW-1:0] wr_data,
  input logic [PW-1:0] rd_data,
  input logic          etu_tick,
  input logic          card_clk
);
  // R2: upper readback bits stay zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PW-1:RW] == '0);

  // R2: a write shows on the readback one cycle later
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[RW-1:0] == $past(wr_data[RW-1:0]));

  // R3: a tick always flips the card clock
  a_r3_tick_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |=> card_clk != $past(card_clk));

  // R3 / R5: ticks never back to back, even with ratio zero
  a_r3_no_double_tick: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |=> !etu_tick);

  // R4: no card clock change without a tick
  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !etu_tick |=> $stable(card_clk));
endmodule

bind sc_clkdiv sc_clkdiv_checker #(.RW(RW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .etu_tick (etu_tick),
  .card_clk (card_clk)
);

// File: tb/test_sc_clkdiv.sv
`timescale 1ns/1ps
module test_sc_clkdiv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       etu_tick;
  logic       card_clk;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;   // 50 MHz

  sc_clkdiv i_sc_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .etu_tick(etu_tick), .card_clk(card_clk)
  );

  localparam int NV = 8;
  localparam logic [7:0] WR_TAB [0:NV-1] =
    '{8'h00, 8'hFF, 8'hC5, 8'h01, 8'h3F, 8'h40, 8'h0C, 8'h07};
  localparam logic [7:0] RD_TAB [0:NV-1] =
    '{8'h00, 8'h3F, 8'h05, 8'h01, 8'h3F, 8'h00, 8'h0C, 8'h07};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [5:0] v);
    return (v == 6'd0) ? 2 : int'(v) + 1;
  endfunction

  // phase monitor: every card_clk phase is judged
  logic [5:0] sh_m;
  int         exp_len, cyc, tks;
  logic       prev_ck;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      sh_m = 6'd12; exp_len = 13; cyc = 0; tks = 0; prev_ck = card_clk;
    end else begin
      cyc++;
      if (card_clk != prev_ck) begin
        check(cyc == exp_len, "R4/R6 phase length", cyc, exp_len);
        check(tks == 1, "R3 one tick per phase", tks, 1);
        exp_len = eff_len(sh_m);
        cyc = 0; tks = 0; prev_ck = card_clk;
      end
      if (etu_tick) tks++;
      if (wr_en) sh_m = wr_data[5:0];
    end
  end

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure_phase(output int n);
    logic c0;
    c0 = card_clk; n = 0;
    do begin @(posedge clk); #1; n++; end while (card_clk == c0 && n < 200);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin : main
    int n, tg;
    logic c0;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h0C, "R1 reset readback", rd_data, 8'h0C);
    check(card_clk == 1'b0, "R1 reset card_clk", card_clk, 0);
    check(etu_tick == 1'b0, "R1 reset tick", etu_tick, 0);
    rst_n = 1'b1;
    measure_phase(n);
    check(n == 13, "R1 first phase", n, 13);
    repeat (20) @(negedge clk);

    // table walk: readback vectors (R2), interleaved with waits
    for (int i = 0; i < NV; i++) begin
      do_write(WR_TAB[i]);
      check(rd_data == RD_TAB[i], "R2 readback", rd_data, RD_TAB[i]);
      repeat (3 + ($urandom % 40)) @(negedge clk);
    end

    // R5: zero behaves as one
    do_write(8'h00);
    repeat (20) @(negedge clk);
    tg = 0; c0 = card_clk;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (card_clk != c0) begin tg++; c0 = card_clk; end
    end
    check(tg == 10, "R5 zero ratio toggles in 20 cycles", tg, 10);

    // R7: write on the tick cycle
    do_write(8'h03);
    repeat (20) @(negedge clk);
    do @(negedge clk); while (!etu_tick);
    wr_en = 1'b1; wr_data = 8'h09;
    @(posedge clk); #1;
    @(negedge clk); wr_en = 1'b0;
    measure_phase(n);
    check(n == 4, "R7 phase after coincident write keeps old ratio", n, 4);
    measure_phase(n);
    check(n == 10, "R6 following phase uses new ratio", n, 10);

    // R6: random mid-period writes
    for (int j = 0; j < 300; j++) begin
      repeat ($urandom % 25) @(negedge clk);
      do_write(8'($urandom));
    end
    repeat (300) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule